// File: doc/BRIEF.md
# Frozen-Angle Byte Readout Port

This block sits between two angle-tracking channels and a host that reads their positions over one shared 8-bit data bus. Each channel presents a free-running 16-bit angle word. Per channel, a hold register follows that word on every clock. An active-low hold input freezes the register so the host can collect both halves of a coherent angle while the channel's own counter keeps moving.

Each channel has its own two active-low byte selects: one for the upper half and one for the lower half of its held word. Exactly one asserted select drives the matching byte onto the shared bus, with its output-enable raised, one clock later. With no select asserted the bus is released. If two or more selects are asserted together, across any mix of channels, nothing is driven and a contention flag is raised instead. The pad ring turns `bus_data` and `bus_oe` into the real tri-state pins.

Top module: `angle_readout_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, both hold registers clear to zero and `bus_oe`, `bus_data` and `bus_clash` are all 0 after that edge.
- R2: When `hold_n[c]` is 1 at a clock edge, channel c's hold register takes the value of `ch_angle[16c+15:16c]` at that edge.
- R3: When `hold_n[c]` is 0 at a clock edge, channel c's hold register keeps its value, whatever `ch_angle` does.
- R4: When `hi_sel_n[c]` is the only asserted (0) select at an edge, after that edge `bus_oe` is 1 and `bus_data` equals bits 15:8 of channel c's held word as it was before the edge. Bit 15 is the most significant angle bit and appears on `bus_data[7]`.
- R5: When `lo_sel_n[c]` is the only asserted select at an edge, after that edge `bus_oe` is 1 and `bus_data` equals bits 7:0 of channel c's held word as it was before the edge.
- R6: When no select is asserted at an edge, after that edge `bus_oe` is 0 and `bus_data` is 0.
- R7: When two or more selects are asserted at an edge, after that edge `bus_oe` is 0, `bus_data` is 0 and `bus_clash` is 1; otherwise `bus_clash` is 0 after the edge.
- R8: The hold input of one channel has no effect on the other channel's hold register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_angle | input | 32 | Live angle words, channel c in bits 16c+15:16c |
| hold_n | input | 2 | Per-channel freeze, active low |
| hi_sel_n | input | 2 | Per-channel upper-byte select, active low |
| lo_sel_n | input | 2 | Per-channel lower-byte select, active low |
| bus_data | output | 8 | Byte for the shared bus, 0 when not driven |
| bus_oe | output | 1 | Bus output enable; 0 means high impedance |
| bus_clash | output | 1 | More than one select was asserted |

## Verification
The bench freezes one channel, keeps moving its angle input, and reads both bytes. A register that leaked through while held would show the newer angle. Reads of the other channel at the same time catch a hold that reaches the wrong channel. Two selects on the same channel, and selects on different channels, are asserted together. A design that drove one of them, or OR-ed the bytes, would show a nonzero bus or a raised enable where both must be 0. Reads on the clock right after a hold releases expose an off-by-one in the register's update, and reads of the upper half expose swapped byte halves.

// File: rtl/angle_port_pkg.sv
// Shared constants and helpers for the angle readout port.
// Assumes the angle word is exactly two bus bytes wide.
package angle_port_pkg;
    localparam int BYTE_W     = 8;
    localparam int HALVES     = 2;
    localparam int HALF_UPPER = 0;
    localparam int HALF_LOWER = 1;
endpackage

// File: rtl/angle_hold_reg.sv
// One channel's hold register: follows the live angle each clock and
// freezes while hold_n is low. Assumes synchronous active-low reset.
module angle_hold_reg #(
    parameter int ANGLE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_n,
    input  logic [ANGLE_W-1:0] angle_in,
    output logic [ANGLE_W-1:0] held
);
    // Track or freeze the channel angle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (hold_n)
            held <= angle_in;
    end

    assert_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n |=> (held == $past(angle_in)));

    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> $stable(held));
endmodule

// File: rtl/byte_select_decode.sv
// Turns the active-high select lanes into a one-hot grant, or no grant
// and a clash flag when more than one lane asks. Purely combinational.
module byte_select_decode #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] req,
    output logic [LANES-1:0] grant,
    output logic             clash
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] req_cnt;

    // Count asserted lanes and grant only a lone requester.
    always_comb begin
        req_cnt = '0;
        for (int l = 0; l < LANES; l++)
            req_cnt = req_cnt + CNT_W'(req[l]);
        grant = (req_cnt == CNT_W'(1)) ? req : '0;
        clash = (req_cnt > CNT_W'(1));
    end
endmodule

// File: rtl/bus_byte_driver.sv
// Registered bus stage: picks the granted byte with an AND-OR mux and
// registers data, output enable and clash. Assumes grant is one-hot or zero.
module bus_byte_driver #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*BYTE_W-1:0] lane_bytes,
    input  logic [LANES-1:0]        grant,
    input  logic                    clash_in,
    output logic [BYTE_W-1:0]       bus_data,
    output logic                    bus_oe,
    output logic                    bus_clash
);
    logic [BYTE_W-1:0] mux_byte;

    // AND-OR select of the granted lane byte.
    always_comb begin
        mux_byte = '0;
        for (int l = 0; l < LANES; l++)
            mux_byte = mux_byte | (lane_bytes[l*BYTE_W +: BYTE_W] & {BYTE_W{grant[l]}});
    end

    // Register the bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data  <= '0;
            bus_oe    <= 1'b0;
            bus_clash <= 1'b0;
        end else begin
            bus_data  <= mux_byte;
            bus_oe    <= |grant;
            bus_clash <= clash_in;
        end
    end
endmodule

// File: rtl/angle_readout_port.sv
// Shared byte readout for NUM_CH angle channels. Each channel has a hold
// register and two byte selects; one lone select drives the bus a clock
// later. Assumes ANGLE_W is twice the bus width.
module angle_readout_port
    import angle_port_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int ANGLE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*ANGLE_W-1:0] ch_angle,
    input  logic [NUM_CH-1:0]         hold_n,
    input  logic [NUM_CH-1:0]         hi_sel_n,
    input  logic [NUM_CH-1:0]         lo_sel_n,
    output logic [BYTE_W-1:0]         bus_data,
    output logic                      bus_oe,
    output logic                      bus_clash
);
    localparam int LANES = NUM_CH * HALVES;

    logic [LANES-1:0]        lane_req;
    logic [LANES-1:0]        lane_grant;
    logic                    lane_clash;
    logic [LANES*BYTE_W-1:0] lane_bytes;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [ANGLE_W-1:0] held;

        angle_hold_reg #(.ANGLE_W(ANGLE_W)) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_n   (hold_n[c]),
            .angle_in (ch_angle[c*ANGLE_W +: ANGLE_W]),
            .held     (held)
        );

        assign lane_req[c*HALVES + HALF_UPPER] = ~hi_sel_n[c];
        assign lane_req[c*HALVES + HALF_LOWER] = ~lo_sel_n[c];
        assign lane_bytes[(c*HALVES + HALF_UPPER)*BYTE_W +: BYTE_W] = held[ANGLE_W-1 -: BYTE_W];
        assign lane_bytes[(c*HALVES + HALF_LOWER)*BYTE_W +: BYTE_W] = held[BYTE_W-1:0];
    end

    byte_select_decode #(.LANES(LANES)) u_dec (
        .req   (lane_req),
        .grant (lane_grant),
        .clash (lane_clash)
    );

    bus_byte_driver #(.LANES(LANES), .BYTE_W(BYTE_W)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_bytes (lane_bytes),
        .grant      (lane_grant),
        .clash_in   (lane_clash),
        .bus_data   (bus_data),
        .bus_oe     (bus_oe),
        .bus_clash  (bus_clash)
    );

    assert_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({~hi_sel_n, ~lo_sel_n}) > 1) |=> (bus_clash && !bus_oe && bus_data == '0));

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&hi_sel_n) && (&lo_sel_n)) |=> (!bus_oe && bus_data == '0 && !bus_clash));

    assert_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({~hi_sel_n, ~lo_sel_n}) == 1) |=> (bus_oe && !bus_clash));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!bus_oe && !bus_clash && bus_data == '0));
endmodule

// File: tb/angle_readout_port_tb.sv
module angle_readout_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ch_angle = '0;
    logic [1:0]  hold_n = 2'b11;
    logic [1:0]  hi_sel_n = 2'b11;
    logic [1:0]  lo_sel_n = 2'b11;
    logic [7:0]  bus_data;
    logic        bus_oe;
    logic        bus_clash;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: held words per channel, expected outputs
    int unsigned ref_held [2];
    int unsigned exp_data;
    bit exp_oe, exp_clash;

    always #4 clk = ~clk;

    angle_readout_port u_dut (
        .clk(clk), .rst_n(rst_n), .ch_angle(ch_angle), .hold_n(hold_n),
        .hi_sel_n(hi_sel_n), .lo_sel_n(lo_sel_n),
        .bus_data(bus_data), .bus_oe(bus_oe), .bus_clash(bus_clash)
    );

    // Model one edge from current inputs, advance, compare at negedge.
    task automatic step(input string tag);
        int asked = 0;
        int unsigned pick = 0;
        if (!rst_n) begin
            exp_oe = 0; exp_clash = 0; exp_data = 0;
            ref_held[0] = 0; ref_held[1] = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (!hi_sel_n[c]) begin asked++; pick = (ref_held[c] >> 8) & 8'hFF; end
                if (!lo_sel_n[c]) begin asked++; pick = ref_held[c] & 8'hFF; end
            end
            exp_oe    = (asked == 1);
            exp_clash = (asked > 1);
            exp_data  = (asked == 1) ? pick : 0;
            for (int c = 0; c < 2; c++)
                if (hold_n[c]) ref_held[c] = (ch_angle >> (16*c)) & 16'hFFFF;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (bus_oe !== exp_oe || bus_clash !== exp_clash || bus_data !== exp_data[7:0]) begin
            errors++;
            $display("FAIL %s: oe/clash/data actual %0b/%0b/%02h expected %0b/%0b/%02h",
                     tag, bus_oe, bus_clash, bus_data, exp_oe, exp_clash, exp_data[7:0]);
        end
    endtask

    // Request one read; returns to idle selects afterwards.
    task automatic rd(input int ch, input bit upper, input string tag);
        if (upper) hi_sel_n[ch] = 1'b0; else lo_sel_n[ch] = 1'b0;
        step(tag);
        hi_sel_n = 2'b11; lo_sel_n = 2'b11;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        ch_angle = 32'h1234_ABCD;
        hi_sel_n = 2'b10;
        step("R1"); step("R1"); step("R1");
        hi_sel_n = 2'b11;
        rst_n = 1'b1;
        step("R6");
        // Tracking and byte placement
        ch_angle = 32'h5A3C_C3A5; step("R2");
        rd(0, 1, "R4"); rd(0, 0, "R5"); rd(1, 1, "R4"); rd(1, 0, "R5");
        // Freeze channel 0, keep channel 1 tracking
        hold_n = 2'b10; step("R3");
        ch_angle = 32'hFFFF_0001;
        rd(0, 1, "R3"); rd(0, 0, "R3"); rd(1, 1, "R8"); rd(1, 0, "R8");
        ch_angle = 32'h8000_7FFF;
        rd(0, 1, "R3"); rd(1, 0, "R8");
        // Freeze channel 1 instead
        hold_n = 2'b01; step("R8");
        ch_angle = 32'h0F0F_F0F0;
        rd(1, 1, "R3"); rd(0, 0, "R8");
        hold_n = 2'b11;
        rd(1, 1, "R2"); rd(1, 0, "R2");
        // Contention: same channel, cross channel, all
        hi_sel_n = 2'b10; lo_sel_n = 2'b10; step("R7");
        hi_sel_n = 2'b10; lo_sel_n = 2'b01; step("R7");
        hi_sel_n = 2'b00; lo_sel_n = 2'b11; step("R7");
        hi_sel_n = 2'b00; lo_sel_n = 2'b00; step("R7");
        hi_sel_n = 2'b11; lo_sel_n = 2'b11; step("R6");
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            ch_angle = $urandom;
            hold_n   = 2'($urandom);
            hi_sel_n = 2'($urandom | $urandom);
            lo_sel_n = 2'($urandom | $urandom);
            step("R2 R3 R4 R5 R6 R7 R8");
        end
        // Reset mid-run
        rst_n = 1'b0; lo_sel_n = 2'b10; step("R1");
        rst_n = 1'b1; lo_sel_n = 2'b11; hold_n = 2'b00; step("R1");
        rd(0, 1, "R1"); rd(1, 0, "R1");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule